// File: doc/BRIEF.md
# Dual-Phase Count Capture

This block records the value of a free-running counter when an asynchronous event line rises, and it guarantees that the recorded value always belongs to the same counter edge relative to the event. The counter advances on the rising edge of an in-phase reference clock.

The event is taken into the clock domain along two synchronisers that run side by side. One launches on the rising edge of the in-phase clock. The other launches half a period later, on the falling edge. Only one of them can be close to its sampling edge for a given event.

The rising event edge also clocks a single flop that samples the level of a quadrature clock, which runs a quarter period behind the in-phase clock. After one settling stage, that bit picks the synchroniser that had a safe margin. The final capture register takes the counter value only when the picked path reports the event.

Only one result is held at a time. After a capture, further events are ignored until the consumer acknowledges the result. Any offset of the quadrature clock between a few percent and a half period keeps the selection sound, because each path is safe across the whole window in which it can be chosen.

Top module: `dps_count_sampler`

## Requirements
- R1: The internal counter is CNT_W bits wide and is held at 0 while reset is asserted. It holds 0 through the second in-phase rising edge after `rst_ni` rises. From the third edge onward it adds 1 on every in-phase rising edge, wrapping modulo 2^CNT_W.
- R2: A rising edge on `event_i` samples the level of `clk_q_i`. With the capture, `sel_o` reports that sampled level. A value of 1 means the rising-edge path was used, and 0 means the falling-edge path was used.
- R3: Let m be the index of the last in-phase rising edge before the most recent rising edge of `clk_q_i` that precedes the event. Edges are counted from 1 after reset release. `count_o` then equals the counter value just after in-phase edge m+SYNC_DEPTH, which is m+SYNC_DEPTH-2 modulo 2^CNT_W. This holds for every event position within the clock period, with no off-by-one.
- R4: `valid_o` is high for exactly one in-phase cycle. It rises on in-phase edge m+SYNC_DEPTH+1, and `count_o` and `sel_o` take their new values on that same edge.
- R5: After a capture, further rises of `event_i` produce no `valid_o`, and `count_o` and `sel_o` stay unchanged until `ack_i` is seen high on an in-phase rising edge.
- R6: After `ack_i`, the block re-arms only once both synchronised event levels are low. If `event_i` is still high when `ack_i` arrives, nothing is captured until the event falls and rises again.
- R7: From reset until the first capture, `count_o` is 0, `sel_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | In-phase reference clock; the counter and capture logic run on it |
| clk_q_i | input | 1 | Quadrature clock, a quarter period behind `clk_i`; used only as data for the selector flop |
| rst_ni | input | 1 | Asynchronous active-low reset, released internally in step with `clk_i` |
| event_i | input | 1 | Asynchronous event line; its rising edge is time-stamped |
| ack_i | input | 1 | Consumer acknowledge; frees the block for the next event |
| count_o | output | CNT_W | Captured counter value |
| sel_o | output | 1 | Quadrature level seen at the event; identifies the path that was used |
| valid_o | output | 1 | One-cycle pulse marking a new capture |

## Verification
The hardest condition to reach from the ports is an event that lands on either side of a clock edge where one synchroniser is at risk. This is where the two paths disagree by a cycle and the selector alone decides the result. The stimulus steps the event across a whole in-phase period in 1 ns steps with a fractional offset, so no step coincides with an edge of either clock. Each step crosses from one selector window into the other at a known point. The bench predicts the expected count and edge index from the last quadrature rising edge it observed, not from the design.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [1:0] {
    CAP_REARM = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_HOLD  = 2'd2
  } cap_state_e;

endpackage

// File: rtl/dps_counter.sv
module dps_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R1: every enabled edge advances the count by exactly one
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/dps_sync_path.sv
module dps_sync_path #(
  parameter int SYNC_DEPTH     = 2,
  parameter bit LAUNCH_ON_FALL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o
);

  localparam int TAIL = SYNC_DEPTH - 1;

  logic            launch_q;
  logic [TAIL-1:0] tail_q;
  logic [TAIL-1:0] tail_d;

  generate
    if (LAUNCH_ON_FALL) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) launch_q <= 1'b0;
        else         launch_q <= async_i;
      end
    end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) launch_q <= 1'b0;
        else         launch_q <= async_i;
      end
    end
  endgenerate

  always_comb begin
    tail_d[0] = launch_q;
    for (int i = 1; i < TAIL; i++) tail_d[i] = tail_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tail_q <= '0;
    else         tail_q <= tail_d;
  end

  assign level_o = tail_q[TAIL-1];

endmodule

// File: rtl/dps_phase_pick.sv
module dps_phase_pick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic clk_q_i,
  output logic sel_o
);

  logic raw_q;
  logic settle_q;

  // event edge takes a snapshot of the quadrature clock level
  always_ff @(posedge event_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= clk_q_i;
  end

  // one settling stage in the reference domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) settle_q <= 1'b0;
    else         settle_q <= raw_q;
  end

  assign sel_o = settle_q;

endmodule

// File: rtl/dps_capture.sv
module dps_capture
  import dps_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             lvl_rise_i,
  input  logic             lvl_fall_i,
  input  logic             sel_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             sel_o,
  output logic             valid_o
);

  cap_state_e       st_q, st_d;
  logic             load;
  logic             hit;
  logic [CNT_W-1:0] cap_q;
  logic             csel_q;
  logic             valid_q;

  assign hit = sel_i ? lvl_rise_i : lvl_fall_i;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    unique case (st_q)
      CAP_REARM: if (!lvl_rise_i && !lvl_fall_i) st_d = CAP_ARMED;
      CAP_ARMED: if (hit) begin
        st_d = CAP_HOLD;
        load = 1'b1;
      end
      CAP_HOLD:  if (ack_i) st_d = CAP_REARM;
      default:   st_d = CAP_REARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= CAP_REARM;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= load;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      csel_q <= 1'b0;
    end else if (load) begin
      cap_q  <= cnt_i;
      csel_q <= sel_i;
    end
  end

  assign count_o = cap_q;
  assign sel_o   = csel_q;
  assign valid_o = valid_q;

  // R4: a capture is announced for a single cycle
  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R5: held result does not move while waiting for acknowledge
  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CAP_HOLD && !ack_i) |=> ($stable(cap_q) && $stable(csel_q)));

  // R5: no new announcement while a result is held
  a_r5_no_valid_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CAP_HOLD && !ack_i) |=> !valid_q);

  // R6: leaving the hold state needs an acknowledge
  a_r6_ack_to_leave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CAP_HOLD && !ack_i) |=> st_q == CAP_HOLD);

endmodule

// File: rtl/dps_count_sampler.sv
module dps_count_sampler #(
  parameter int CNT_W      = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             clk_q_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             sel_o,
  output logic             valid_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_s;
  logic [CNT_W-1:0] cnt;
  logic             lvl_rise;
  logic             lvl_fall;
  logic             sel_set;

  // asynchronous assert, release aligned to clk_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_s = rst_sync_q[1];

  dps_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_s),
    .cnt_o  (cnt)
  );

  dps_sync_path #(.SYNC_DEPTH(SYNC_DEPTH), .LAUNCH_ON_FALL(1'b0)) u_path_rise (
    .clk_i   (clk_i),
    .rst_ni  (rst_s),
    .async_i (event_i),
    .level_o (lvl_rise)
  );

  dps_sync_path #(.SYNC_DEPTH(SYNC_DEPTH), .LAUNCH_ON_FALL(1'b1)) u_path_fall (
    .clk_i   (clk_i),
    .rst_ni  (rst_s),
    .async_i (event_i),
    .level_o (lvl_fall)
  );

  dps_phase_pick u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_s),
    .event_i (event_i),
    .clk_q_i (clk_q_i),
    .sel_o   (sel_set)
  );

  dps_capture #(.CNT_W(CNT_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_s),
    .cnt_i      (cnt),
    .lvl_rise_i (lvl_rise),
    .lvl_fall_i (lvl_fall),
    .sel_i      (sel_set),
    .ack_i      (ack_i),
    .count_o    (count_o),
    .sel_o      (sel_o),
    .valid_o    (valid_o)
  );

  // R7: outputs stay quiet while reset is held
  a_r7_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!valid_o && count_o == '0 && !sel_o));

endmodule

// File: tb/dps_count_sampler_tb.sv
`timescale 1ns/1ps
module dps_count_sampler_tb;

  localparam int  CNT_W      = 16;
  localparam int  SYNC_DEPTH = 2;
  localparam real CLK_PERIOD = 40.0;

  typedef struct {
    logic [CNT_W-1:0] cnt;
    logic             sel;
    int               edge_idx;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             clk_q = 1'b0;
  logic             rst_n = 1'b0;
  logic             ev    = 1'b0;
  logic             ack   = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic             sel_o;
  logic             valid_o;

  int   checks = 0;
  int   errs   = 0;
  int   edges  = 0;
  int   q_m    = 0;
  bit   done   = 1'b0;
  exp_t sb[$];

  dps_count_sampler #(.CNT_W(CNT_W), .SYNC_DEPTH(SYNC_DEPTH)) u_dut (
    .clk_i   (clk_i),
    .clk_q_i (clk_q),
    .rst_ni  (rst_n),
    .event_i (ev),
    .ack_i   (ack),
    .count_o (count_o),
    .sel_o   (sel_o),
    .valid_o (valid_o)
  );

  initial begin
    forever begin
      clk_i = 1'b1; #(CLK_PERIOD/4.0);
      clk_q = 1'b1; #(CLK_PERIOD/4.0);
      clk_i = 1'b0; #(CLK_PERIOD/4.0);
      clk_q = 1'b0; #(CLK_PERIOD/4.0);
    end
  end

  always @(posedge clk_i) if (rst_n) edges = edges + 1;
  always @(posedge clk_q) q_m = edges;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a capture is announced
  always @(negedge clk_i) begin
    if (rst_n && valid_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R5", "unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(count_o == e.cnt, "R3", "captured count", count_o, e.cnt);
        check(sel_o == e.sel, "R2", "selector bit", sel_o, e.sel);
        check(edges == e.edge_idx, "R4", "valid edge index", edges, e.edge_idx);
      end
    end
  end

  // driver: raise the event at a given offset after an in-phase edge
  task automatic raise_at(input real off);
    exp_t e;
    @(posedge clk_i);
    #(off);
    ev = 1'b1;
    e.cnt      = CNT_W'(q_m + SYNC_DEPTH - 2);
    e.sel      = clk_q;
    e.edge_idx = q_m + SYNC_DEPTH + 1;
    sb.push_back(e);
    repeat (6) @(posedge clk_i);
    #1 ev = 1'b0;
    repeat (2) @(negedge clk_i);
    check(sb.size() == 0, "R4", "capture announced", sb.size(), 0);
  endtask

  task automatic do_ack();
    @(negedge clk_i) ack = 1'b1;
    @(negedge clk_i) ack = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000.0);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] held_cnt;
    logic             held_sel;
    // R7: quiet outputs in and just after reset
    #(CLK_PERIOD * 2.0 + 5.0);
    check(count_o == '0 && !valid_o && !sel_o, "R7", "outputs in reset",
          {count_o, sel_o, valid_o}, 0);
    #(CLK_PERIOD);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_i);
    check(count_o == '0 && !valid_o && !sel_o, "R7", "outputs after release",
          {count_o, sel_o, valid_o}, 0);

    // R1 R2 R3 R4: sweep the event across a full period
    for (int k = 0; k < 40; k++) begin
      raise_at(0.3 + real'(k));
      do_ack();
    end

    // R5: extra event edges while a result is held
    raise_at(15.3);
    held_cnt = count_o;
    held_sel = sel_o;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk_i);
      #3 ev = 1'b1;
      repeat (4) @(negedge clk_i);
      ev = 1'b0;
      repeat (3) @(negedge clk_i);
    end
    check(count_o == held_cnt, "R5", "count kept while held", count_o, held_cnt);
    check(sel_o == held_sel, "R5", "selector kept while held", sel_o, held_sel);

    // R6: event still high when acknowledged
    ev = 1'b1;
    repeat (4) @(negedge clk_i);
    do_ack();
    repeat (8) @(negedge clk_i);
    check(count_o == held_cnt, "R6", "no capture with event held high",
          count_o, held_cnt);
    ev = 1'b0;
    repeat (4) @(negedge clk_i);
    raise_at(33.7);
    check(count_o != held_cnt, "R6", "capture after re-arm", count_o, held_cnt);
    do_ack();
    raise_at(5.1);
    do_ack();

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule